// File: doc/BRIEF.md
# Instruction Translation Buffer with Same-Page Bypass

This block sits in the fetch stage next to the instruction cache. It turns the virtual page number of each fetch address into a physical frame number. Fetches usually stay on one page for a long time. The block therefore keeps the most recent translation and reuses it for any fetch that is known to remain on that page. In that case the set-associative tag store is not read, which saves array energy. The translation store itself has 16 sets of 4 ways with least-recently-used replacement, and pages are 4 KiB.

A full lookup happens in four cases:

- the instruction carries a page-cross hint, meaning sequential fetch walked off the page;
- a redirect (taken branch or jump) targets a page other than the stored one;
- no translation is stored;
- the block has just been reset or flushed.

A lookup that misses reports a stall of 29 cycles, which is a 30-cycle miss latency minus one. It then raises a refill request and ignores further fetches until the refill answer arrives. The answer is written into the least-recently-used way of the indexed set. Five event counters expose the traffic for energy accounting.

Top module: `ifetch_tlb`

## Requirements
- R1: Synchronous active-high `rst` clears every counter, every entry, the stored translation and any pending refill. `flush` has the same effect on state but does not clear the counters, and it wins over a fetch or a refill answer in the same cycle. After either one, the next accepted fetch has `xl_lookup`=1.
- R2: A fetch is accepted when `fetch_valid`=1, `xl_busy`=0 and `flush`=0. A fetch is bypassed when a translation is stored, `cross_hint`=0, and either `redirect`=0 or the fetch page equals the stored page. In the cycle after a bypassed fetch: `xl_valid`=1, `xl_hit`=1, `xl_lookup`=0, `xl_stall`=0, and `xl_frame` equals the stored frame.
- R3: An accepted fetch with `cross_hint`=1 always performs a lookup (`xl_lookup`=1), even on the stored page.
- R4: An accepted fetch with `redirect`=1 to a page different from the stored page performs a lookup. A redirect to the stored page is bypassed.
- R5: The page number is `fetch_pc[31:12]`, and the set index is its low 4 bits. A lookup that matches a valid entry gives `xl_hit`=1, `xl_stall`=0 and that entry's frame. The entry becomes most-recently-used, and its translation becomes the stored translation.
- R6: A lookup that misses gives `xl_hit`=0, `xl_frame`=0 and `xl_stall`=29. From the next cycle `xl_busy` and `refill_req` are 1 until the refill answer is taken. While busy, fetches are ignored and `xl_valid` stays 0.
- R7: While busy, `refill_vpn` holds the missing page number. When `refill_ack`=1, `refill_pfn` is written into the least-recently-used way of that page's set, that way becomes most-recently-used, the translation becomes the stored one, and busy clears.
- R8: When a fifth page is filled into a full set, the page used least recently (by fill or lookup hit) is evicted, and a later lookup of it misses.
- R9: `cnt_fetch`, `cnt_lookup`, `cnt_hit`, `cnt_miss` and `cnt_bypass` each count accepted fetches, lookups, lookup hits, lookup misses and bypassed fetches.
- R10: A flush invalidates all entries, so a page cached before it misses on its next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all translations |
| fetch_valid | input | 1 | Fetch address present |
| fetch_pc | input | 32 | Fetch virtual address |
| redirect | input | 1 | Fetch is a branch/jump target |
| cross_hint | input | 1 | Sequential fetch crossed a page |
| refill_ack | input | 1 | Refill answer present |
| refill_pfn | input | 20 | Frame number of the refill answer |
| refill_req | output | 1 | Refill request pending |
| refill_vpn | output | 20 | Page number being refilled |
| xl_valid | output | 1 | Result of an accepted fetch present |
| xl_hit | output | 1 | Translation available |
| xl_frame | output | 20 | Translated frame number |
| xl_lookup | output | 1 | Tag arrays were read |
| xl_stall | output | 5 | Extra fetch cycles to block |
| xl_busy | output | 1 | Waiting for a refill |
| cnt_fetch | output | 32 | Accepted fetches |
| cnt_lookup | output | 32 | Full lookups |
| cnt_hit | output | 32 | Lookup hits |
| cnt_miss | output | 32 | Lookup misses |
| cnt_bypass | output | 32 | Bypassed fetches |

## Verification
A flush can land in the same cycle as an accepted fetch, and it can also land in the same cycle as a refill answer. The bench provokes both cases directly. In the first case it checks that no result appears and that the following fetch performs a lookup. In the second case it checks that busy clears but the refilled page still misses afterwards. A behavioural model with per-set recency queues predicts every output on every clock, including which page an overfull set evicts.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_REFILL = 1'b1} fill_state_t;
endpackage

// File: rtl/itlb_lru.sv
module itlb_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic [WAY_W-1:0] victim_way
);
  // age 0 = most recent, WAYS-1 = least recent; ages in a set are a permutation
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age_q[touch_set][touch_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < touched_age)
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[rd_set][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
  end
endmodule

// File: rtl/itlb_array.sv
module itlb_array #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  parameter int PFN_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PFN_W-1:0] wr_pfn,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [PFN_W-1:0] hit_pfn
);
  logic [WAYS-1:0]  hit_vec;
  logic [PFN_W-1:0] pfn_vec [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [PFN_W-1:0] pfn_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic             sel;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    // storage without reset so it maps onto distributed RAM
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[wr_set] <= wr_tag;
        pfn_q[wr_set] <= wr_pfn;
      end
    end

    always_ff @(posedge clk) begin
      if (rst || clr) vld_q <= '0;
      else if (sel)   vld_q[wr_set] <= 1'b1;
    end

    assign hit_vec[w] = vld_q[rd_set] && (tag_q[rd_set] == rd_tag);
    assign pfn_vec[w] = pfn_q[rd_set];
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    hit_pfn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way = WAY_W'(w);
        hit_pfn = pfn_vec[w];
      end
    end
  end
endmodule

// File: rtl/ifetch_tlb.sv
module ifetch_tlb
  import itlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  parameter int SETS      = 16,
  parameter int WAYS      = 4,
  parameter int HIT_LAT   = 1,
  parameter int MISS_LAT  = 30,
  parameter int CNT_W     = 32,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(SETS),
  localparam int TAG_W    = VPN_W - IDX_W,
  localparam int WAY_W    = $clog2(WAYS),
  localparam int STALL_W  = $clog2(MISS_LAT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               fetch_valid,
  input  logic [VA_W-1:0]    fetch_pc,
  input  logic               redirect,
  input  logic               cross_hint,
  input  logic               refill_ack,
  input  logic [PFN_W-1:0]   refill_pfn,
  output logic               refill_req,
  output logic [VPN_W-1:0]   refill_vpn,
  output logic               xl_valid,
  output logic               xl_hit,
  output logic [PFN_W-1:0]   xl_frame,
  output logic               xl_lookup,
  output logic [STALL_W-1:0] xl_stall,
  output logic               xl_busy,
  output logic [CNT_W-1:0]   cnt_fetch,
  output logic [CNT_W-1:0]   cnt_lookup,
  output logic [CNT_W-1:0]   cnt_hit,
  output logic [CNT_W-1:0]   cnt_miss,
  output logic [CNT_W-1:0]   cnt_bypass
);
  localparam logic [STALL_W-1:0] HIT_STALL  = STALL_W'(HIT_LAT - 1);
  localparam logic [STALL_W-1:0] MISS_STALL = STALL_W'(MISS_LAT - 1);

  fill_state_t      state_q;
  logic [VPN_W-1:0] pend_vpn_q;
  logic             last_vld_q;
  logic [VPN_W-1:0] last_vpn_q;
  logic [PFN_W-1:0] last_pfn_q;

  logic [VPN_W-1:0] cur_vpn;
  logic [IDX_W-1:0] cur_set, pend_set;
  logic             accept, need_lookup, fill;
  logic             arr_hit;
  logic [WAY_W-1:0] arr_way, victim_way;
  logic [PFN_W-1:0] arr_pfn;
  logic             lru_touch;

  assign cur_vpn  = fetch_pc[VA_W-1:PAGE_BITS];
  assign cur_set  = cur_vpn[IDX_W-1:0];
  assign pend_set = pend_vpn_q[IDX_W-1:0];

  assign accept      = fetch_valid && (state_q == ST_RUN) && !flush;
  assign need_lookup = !last_vld_q || cross_hint || (redirect && (cur_vpn != last_vpn_q));
  assign fill        = (state_q == ST_REFILL) && refill_ack && !flush;
  assign lru_touch   = (accept && need_lookup && arr_hit) || fill;

  itlb_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_array (
    .clk     (clk),
    .rst     (rst),
    .clr     (flush),
    .rd_set  (cur_set),
    .rd_tag  (cur_vpn[VPN_W-1:IDX_W]),
    .wr_en   (fill),
    .wr_set  (pend_set),
    .wr_way  (victim_way),
    .wr_tag  (pend_vpn_q[VPN_W-1:IDX_W]),
    .wr_pfn  (refill_pfn),
    .hit     (arr_hit),
    .hit_way (arr_way),
    .hit_pfn (arr_pfn)
  );

  itlb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (lru_touch),
    .touch_set  (fill ? pend_set : cur_set),
    .touch_way  (fill ? victim_way : arr_way),
    .rd_set     (pend_set),
    .victim_way (victim_way)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state_q    <= ST_RUN;
      last_vld_q <= 1'b0;
      xl_valid   <= 1'b0;
      refill_req <= 1'b0;
      if (rst) begin
        pend_vpn_q <= '0;
        last_vpn_q <= '0;
        last_pfn_q <= '0;
        xl_hit     <= 1'b0;
        xl_frame   <= '0;
        xl_lookup  <= 1'b0;
        xl_stall   <= '0;
      end
    end else begin
      xl_valid <= accept;
      if (accept) begin
        xl_lookup <= need_lookup;
        if (!need_lookup) begin
          xl_hit   <= 1'b1;
          xl_frame <= last_pfn_q;
          xl_stall <= HIT_STALL;
        end else if (arr_hit) begin
          xl_hit     <= 1'b1;
          xl_frame   <= arr_pfn;
          xl_stall   <= HIT_STALL;
          last_vld_q <= 1'b1;
          last_vpn_q <= cur_vpn;
          last_pfn_q <= arr_pfn;
        end else begin
          xl_hit     <= 1'b0;
          xl_frame   <= '0;
          xl_stall   <= MISS_STALL;
          state_q    <= ST_REFILL;
          pend_vpn_q <= cur_vpn;
          refill_req <= 1'b1;
          last_vld_q <= 1'b0;
        end
      end
      if (fill) begin
        state_q    <= ST_RUN;
        refill_req <= 1'b0;
        last_vld_q <= 1'b1;
        last_vpn_q <= pend_vpn_q;
        last_pfn_q <= refill_pfn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_fetch  <= '0;
      cnt_lookup <= '0;
      cnt_hit    <= '0;
      cnt_miss   <= '0;
      cnt_bypass <= '0;
    end else if (accept) begin
      cnt_fetch <= cnt_fetch + 1'b1;
      if (!need_lookup) cnt_bypass <= cnt_bypass + 1'b1;
      else begin
        cnt_lookup <= cnt_lookup + 1'b1;
        if (arr_hit) cnt_hit  <= cnt_hit + 1'b1;
        else         cnt_miss <= cnt_miss + 1'b1;
      end
    end
  end

  assign xl_busy    = (state_q == ST_REFILL);
  assign refill_vpn = pend_vpn_q;
endmodule

// File: rtl/ifetch_tlb_chk.sv
module ifetch_tlb_chk #(
  parameter int VPN_W    = 20,
  parameter int MISS_LAT = 30,
  parameter int CNT_W    = 32,
  localparam int STALL_W = $clog2(MISS_LAT)
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic               refill_ack,
  input logic               refill_req,
  input logic [VPN_W-1:0]   refill_vpn,
  input logic               xl_valid,
  input logic               xl_hit,
  input logic               xl_lookup,
  input logic [STALL_W-1:0] xl_stall,
  input logic               xl_busy,
  input logic [CNT_W-1:0]   cnt_fetch,
  input logic [CNT_W-1:0]   cnt_lookup,
  input logic [CNT_W-1:0]   cnt_hit,
  input logic [CNT_W-1:0]   cnt_miss,
  input logic [CNT_W-1:0]   cnt_bypass
);
  assert_flush_idle_R1: assert property (@(posedge clk) disable iff (rst)
    flush |=> !xl_valid && !xl_busy && !refill_req);

  assert_bypass_hits_R2: assert property (@(posedge clk) disable iff (rst)
    xl_valid && !xl_lookup |-> xl_hit && xl_stall == '0);

  assert_hit_no_stall_R5: assert property (@(posedge clk) disable iff (rst)
    xl_valid && xl_hit |-> xl_stall == '0);

  assert_miss_stall_R6: assert property (@(posedge clk) disable iff (rst)
    xl_valid && !xl_hit |-> xl_lookup && xl_busy && xl_stall == STALL_W'(MISS_LAT - 1));

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    xl_busy |=> !xl_valid);

  assert_refill_hold_R7: assert property (@(posedge clk) disable iff (rst)
    refill_req && !refill_ack && !flush |=> refill_req && $stable(refill_vpn));

  assert_cnt_split_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_fetch == cnt_lookup + cnt_bypass && cnt_lookup == cnt_hit + cnt_miss);
endmodule

bind ifetch_tlb ifetch_tlb_chk #(
  .VPN_W(VA_W - PAGE_BITS), .MISS_LAT(MISS_LAT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .refill_ack(refill_ack),
  .refill_req(refill_req), .refill_vpn(refill_vpn), .xl_valid(xl_valid),
  .xl_hit(xl_hit), .xl_lookup(xl_lookup), .xl_stall(xl_stall), .xl_busy(xl_busy),
  .cnt_fetch(cnt_fetch), .cnt_lookup(cnt_lookup), .cnt_hit(cnt_hit),
  .cnt_miss(cnt_miss), .cnt_bypass(cnt_bypass)
);

// File: tb/ifetch_tlb_test.sv
`timescale 1ns/1ps
module ifetch_tlb_test;
  logic        clk = 1'b0;
  logic        rst, flush, fetch_valid, redirect, cross_hint, refill_ack;
  logic [31:0] fetch_pc;
  logic [19:0] refill_pfn;
  logic        refill_req, xl_valid, xl_hit, xl_lookup, xl_busy;
  logic [19:0] refill_vpn, xl_frame;
  logic [4:0]  xl_stall;
  logic [31:0] cnt_fetch, cnt_lookup, cnt_hit, cnt_miss, cnt_bypass;

  always #2.5 clk = ~clk;

  ifetch_tlb uut (
    .clk(clk), .rst(rst), .flush(flush), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .redirect(redirect), .cross_hint(cross_hint), .refill_ack(refill_ack),
    .refill_pfn(refill_pfn), .refill_req(refill_req), .refill_vpn(refill_vpn),
    .xl_valid(xl_valid), .xl_hit(xl_hit), .xl_frame(xl_frame), .xl_lookup(xl_lookup),
    .xl_stall(xl_stall), .xl_busy(xl_busy), .cnt_fetch(cnt_fetch), .cnt_lookup(cnt_lookup),
    .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_bypass(cnt_bypass)
  );

  int n_chk = 0, n_fail = 0;

  // behavioural reference: per-set recency queue, most recent first
  int  m_tag [16][4];
  int  m_pfn [16][4];
  bit  m_ok  [16][4];
  int  rq    [16][$];
  bit  m_lv, m_busy;
  int  m_lvpn, m_lpfn, m_pend;
  int  c_fetch, c_look, c_hit, c_miss, c_byp;
  bit  e_valid, e_hit, e_look;
  int  e_frame, e_stall;

  function automatic int pfn_of(int vpn);
    return (vpn * 37 + 5) & 32'hFFFFF;
  endfunction

  function automatic logic [31:0] pc_of(int vpn, int off);
    return {vpn[19:0], off[11:0]};
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 16; s++) begin
      rq[s] = {0, 1, 2, 3};
      for (int w = 0; w < 4; w++) m_ok[s][w] = 1'b0;
    end
    m_lv = 0; m_busy = 0; m_pend = 0; e_valid = 0;
    c_fetch = 0; c_look = 0; c_hit = 0; c_miss = 0; c_byp = 0;
  endtask

  task automatic promote(int s, int w);
    for (int i = 0; i < rq[s].size(); i++)
      if (rq[s][i] == w) begin rq[s].delete(i); break; end
    rq[s].push_front(w);
  endtask

  task automatic model_step();
    int vpn, s, hw;
    bit need;
    e_valid = 0;
    if (flush) begin
      for (int a = 0; a < 16; a++) for (int b = 0; b < 4; b++) m_ok[a][b] = 1'b0;
      m_lv = 0; m_busy = 0;
    end else if (m_busy) begin
      if (refill_ack) begin
        s = m_pend % 16;
        hw = rq[s][3];
        promote(s, hw);
        m_tag[s][hw] = m_pend / 16; m_pfn[s][hw] = refill_pfn; m_ok[s][hw] = 1'b1;
        m_lv = 1; m_lvpn = m_pend; m_lpfn = refill_pfn; m_busy = 0;
      end
    end else if (fetch_valid) begin
      vpn = int'(fetch_pc >> 12);
      e_valid = 1; c_fetch++;
      need = !m_lv || cross_hint || (redirect && vpn != m_lvpn);
      e_look = need;
      if (!need) begin
        c_byp++; e_hit = 1; e_frame = m_lpfn; e_stall = 0;
      end else begin
        c_look++; s = vpn % 16; hw = -1;
        for (int w = 0; w < 4; w++) if (m_ok[s][w] && m_tag[s][w] == vpn / 16) hw = w;
        if (hw >= 0) begin
          c_hit++; promote(s, hw);
          e_hit = 1; e_frame = m_pfn[s][hw]; e_stall = 0;
          m_lv = 1; m_lvpn = vpn; m_lpfn = m_pfn[s][hw];
        end else begin
          c_miss++; e_hit = 0; e_frame = 0; e_stall = 29;
          m_busy = 1; m_pend = vpn; m_lv = 0;
        end
      end
    end
  endtask

  task automatic compare();
    chk("R6 busy", xl_busy, m_busy);
    chk("R6 refill_req", refill_req, m_busy);
    if (m_busy) chk("R7 refill_vpn", refill_vpn, m_pend);
    chk("R2 result valid", xl_valid, e_valid);
    if (e_valid) begin
      chk("R3 lookup flag", xl_lookup, e_look);
      chk("R5 hit flag", xl_hit, e_hit);
      chk("R2 frame", xl_frame, e_frame);
      chk("R6 stall", xl_stall, e_stall);
    end
    chk("R9 cnt_fetch", cnt_fetch, c_fetch);
    chk("R9 cnt_lookup", cnt_lookup, c_look);
    chk("R9 cnt_hit", cnt_hit, c_hit);
    chk("R9 cnt_miss", cnt_miss, c_miss);
    chk("R9 cnt_bypass", cnt_bypass, c_byp);
  endtask

  task automatic cyc(bit v, logic [31:0] pc, bit rd, bit h, bit fl, bit ak);
    fetch_valid = v; fetch_pc = pc; redirect = rd; cross_hint = h;
    flush = fl; refill_ack = ak; refill_pfn = pfn_of(m_pend)[19:0];
    model_step();
    @(posedge clk); #1;
    compare();
  endtask

  task automatic fetch(int vpn, int off, bit rd, bit h);
    cyc(1, pc_of(vpn, off), rd, h, 0, 0);
  endtask

  task automatic refill(int wait_n);
    for (int i = 0; i < wait_n; i++) cyc(1, pc_of(16'h777, 0), 0, 1, 0, 0);
    cyc(0, '0, 0, 0, 0, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1; flush = 0; fetch_valid = 0; fetch_pc = '0; redirect = 0;
    cross_hint = 0; refill_ack = 0; refill_pfn = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    compare();                                        // R1 reset state
    chk("R1 counters zero", cnt_fetch, 0);

    // R1 first fetch after reset looks up and misses; R6 fetches ignored while busy
    fetch(16'h010, 12'h100, 0, 0);
    chk("R1 lookup after reset", xl_lookup, 1);
    refill(3);
    // R2 same-page fetches bypass
    fetch(16'h010, 12'h104, 0, 0);
    chk("R2 bypass no lookup", xl_lookup, 0);
    fetch(16'h010, 12'h108, 0, 0);
    // R3 walking hint on same page forces a lookup that hits
    fetch(16'h010, 12'h10c, 0, 1);
    chk("R3 hint lookup", xl_lookup, 1);
    // R4 redirect to same page bypasses, to another page looks up
    fetch(16'h010, 12'h800, 1, 0);
    chk("R4 same page redirect", xl_lookup, 0);
    fetch(16'h020, 12'h000, 1, 0);
    chk("R4 cross page redirect", xl_lookup, 1);
    refill(0);
    fetch(16'h030, 12'h000, 0, 1); refill(5);
    fetch(16'h040, 12'h000, 0, 1); refill(1);
    // R5 lookup hit refreshes recency of 0x010
    fetch(16'h010, 12'h000, 1, 0);
    chk("R5 refill hit", xl_hit, 1);
    // R8 fifth page in set 0 evicts 0x020
    fetch(16'h050, 12'h000, 0, 1); refill(2);
    fetch(16'h020, 12'h000, 0, 1);
    chk("R8 evicted page misses", xl_hit, 0);
    refill(0);
    fetch(16'h030, 12'h000, 0, 1);
    chk("R8 victim is 0x030 after 0x020 refill", xl_hit, 0);
    refill(1);
    fetch(16'h010, 12'h000, 0, 1);
    chk("R8 recently used kept", xl_hit, 1);
    // other sets
    fetch(16'h123, 12'hfff, 1, 0); refill(0);
    fetch(16'h123, 12'h004, 0, 0);
    // R1/R10 flush together with a fetch
    cyc(1, pc_of(16'h123, 8), 0, 0, 1, 0);
    chk("R1 flush drops fetch", xl_valid, 0);
    fetch(16'h123, 12'h00c, 0, 0);
    chk("R10 flushed page misses", xl_hit, 0);
    // flush together with refill answer
    cyc(1, '0, 0, 0, 1, 1);
    chk("R1 flush clears busy", xl_busy, 0);
    fetch(16'h123, 12'h010, 0, 1);
    chk("R10 refill dropped by flush", xl_hit, 0);
    refill(2);
    fetch(16'h123, 12'h014, 0, 0);
    idle_tail();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic idle_tail();
    for (int i = 0; i < 4; i++) cyc(0, '0, 0, 0, 0, 0);
  endtask
endmodule